// File: doc/BRIEF.md
# Dual-Clock FIFO with Ready Flags

This block carries 36-bit words from a producer on one clock to a consumer on an unrelated clock. The write port presents a word together with chip-select (active low), enable and a direction bit. A word is stored when the input-ready flag is high. The stored words sit in a dual-port array. The read side keeps the oldest word preloaded in an output register, so a consumer sees valid data as soon as the output-ready flag rises. It takes that word by asserting its own chip-select, enable and read select.

Each port works as a valid/ready stream. On the write side, valid is `w_cs_n` low together with `w_en` high and `w_wr` high, and ready is `w_ir`. A word moves only on a rising `wclk` edge where both are true. A producer facing `w_ir` low holds its word; nothing is lost or overwritten. On the read side, valid is `r_or` and ready is the consumer's request (`r_cs_n` low, `r_en` high, `r_rd` high). While no request arrives, `r_data` and `r_or` stay unchanged.

Two programmable thresholds, `x_off` and `y_off`, drive active-low early-warning flags. The almost-empty flag is registered on the read clock and the almost-full flag on the write clock. The pointers cross between the clock domains as Gray code through two-flop synchronizers. The flags therefore clear later than the true state, but never earlier. One active-low reset clears both sides.

Top module: `xclk_fifo`

## Requirements
- R1: A word is accepted on a rising `wclk` edge only when `w_cs_n`=0, `w_en`=1, `w_wr`=1 and `w_ir`=1. A word is consumed on a rising `rclk` edge only when `r_cs_n`=0, `r_en`=1, `r_rd`=1 and `r_or`=1. Any other combination leaves the stored contents unchanged.
- R2: Words leave in the order they were accepted, and the FIFO holds up to DEPTH words (DEPTH 256, 512 or 1024; 36-bit words).
- R3: `w_ir` is low exactly when DEPTH words are held, as seen from the write side. Write attempts while it is low store nothing. It rises again after words have been consumed and that consumption has crossed to the write side.
- R4: After `rst_n` rises, `w_ir` is low on the first rising `wclk` edge and high on the second.
- R5: `r_or` is low while nothing is held, and read requests then have no effect. While `r_or` is high, `r_data` already holds the oldest word and keeps it until that word is consumed.
- R6: When a word is written into an empty FIFO, `r_or` rises on the third rising `rclk` edge after the write edge.
- R7: `r_ae_n` is low when the count of held words (the word in the output register included) is less than or equal to `x_off`, and high otherwise. It is updated on `rclk`.
- R8: `w_af_n` is low when the count of free places (DEPTH minus held words) is less than or equal to `y_off`, and high otherwise. It is updated on `wclk`.
- R9: While `rst_n` is low, `w_ir`=0, `r_or`=0, `r_ae_n`=0 and `w_af_n`=1. Reset must be held low across at least four rising edges of each clock.
- R10: Consuming the last held word clears `r_or` on that edge. Consuming a word while another is held loads the next word into `r_data` on the same edge, and `r_or` stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Active-low reset for both sides |
| wclk | input | 1 | Write-side clock |
| w_cs_n | input | 1 | Write-port chip select, active low |
| w_en | input | 1 | Write-port enable |
| w_wr | input | 1 | Direction: 1 selects write |
| w_data | input | 36 | Word to store |
| y_off | input | AW+1 | Almost-full threshold in free places |
| w_ir | output | 1 | Input ready (space available) |
| w_af_n | output | 1 | Almost-full flag, active low |
| rclk | input | 1 | Read-side clock |
| r_cs_n | input | 1 | Read-port chip select, active low |
| r_en | input | 1 | Read-port enable |
| r_rd | input | 1 | Direction: 1 selects read |
| x_off | input | AW+1 | Almost-empty threshold in held words |
| r_data | output | 36 | Oldest word (first-word fall-through) |
| r_or | output | 1 | Output ready (`r_data` valid) |
| r_ae_n | output | 1 | Almost-empty flag, active low |

## Verification
The block runs with two clocks of the same period, 3 ns apart. The write-to-output-ready latency and the wake-up after reset are counted edge by edge.

Full fill-and-drain sweeps are run with three threshold pairs, one of them zero. They check both warning flags after every single word. They also check that input-ready drops exactly at the capacity boundary, and that writes refused at that point never surface.

A set of single disqualified transfers, each with one qualifier wrong, is checked for effect against the next word that arrives. A long run with unequal, patterned producer and consumer duty cycles checks ordering under concurrent back-pressure on both sides.

// File: rtl/xclk_fifo_pkg.sv
package xclk_fifo_pkg;
  localparam int WORD_W = 36;
  localparam int GMAX   = 16;

  typedef logic [WORD_W-1:0] word_t;

  function automatic logic [GMAX-1:0] gray_to_bin(input logic [GMAX-1:0] g);
    logic [GMAX-1:0] b;
    b[GMAX-1] = g[GMAX-1];
    for (int i = GMAX - 2; i >= 0; i--) begin
      b[i] = b[i+1] ^ g[i];
    end
    return b;
  endfunction
endpackage

// File: rtl/xclk_fifo_sync2.sv
module xclk_fifo_sync2 #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1 <= '0;
      q      <= '0;
    end else begin
      stage1 <= d;
      q      <= stage1;
    end
  end
endmodule

// File: rtl/xclk_fifo_ram.sv
module xclk_fifo_ram #(
  parameter int DEPTH = 256,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic                  wclk,
  input  logic                  we,
  input  logic [AW-1:0]         waddr,
  input  xclk_fifo_pkg::word_t  wdata,
  input  logic [AW-1:0]         raddr,
  output xclk_fifo_pkg::word_t  rdata
);
  xclk_fifo_pkg::word_t mem [DEPTH];

  always_ff @(posedge wclk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/xclk_fifo_wside.sv
module xclk_fifo_wside #(
  parameter int DEPTH = 256,
  localparam int AW = $clog2(DEPTH),
  localparam int PW = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_req,
  input  logic [PW-1:0] rgray_async,
  input  logic [PW-1:0] yoff,
  output logic          ir,
  output logic          af_n,
  output logic          we,
  output logic [AW-1:0] waddr,
  output logic [PW-1:0] wgray
);
  import xclk_fifo_pkg::*;

  logic          wake_q;
  logic [PW-1:0] bin_q, bin_n;
  logic [PW-1:0] rgray_s, rbin;
  logic [PW-1:0] used_n, free_n;

  xclk_fifo_sync2 #(.W(PW)) u_rsync (
    .clk(clk), .rst_n(rst_n), .d(rgray_async), .q(rgray_s)
  );

  assign rbin   = PW'(gray_to_bin(GMAX'(rgray_s)));
  assign we     = wr_req & ir;
  assign bin_n  = bin_q + PW'(we);
  assign used_n = bin_n - rbin;
  assign free_n = PW'(DEPTH) - used_n;
  assign waddr  = bin_q[AW-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wake_q <= 1'b0;
      bin_q  <= '0;
      wgray  <= '0;
      ir     <= 1'b0;
      af_n   <= 1'b1;
    end else begin
      wake_q <= 1'b1;
      bin_q  <= bin_n;
      wgray  <= bin_n ^ (bin_n >> 1);
      ir     <= wake_q && (used_n != PW'(DEPTH));
      af_n   <= free_n > yoff;
    end
  end
endmodule

// File: rtl/xclk_fifo_rside.sv
module xclk_fifo_rside #(
  parameter int DEPTH = 256,
  localparam int AW = $clog2(DEPTH),
  localparam int PW = AW + 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 rd_req,
  input  logic [PW-1:0]        wgray_async,
  input  logic [PW-1:0]        xoff,
  input  xclk_fifo_pkg::word_t mem_data,
  output logic [AW-1:0]        raddr,
  output logic                 ready_out,
  output logic                 ae_n,
  output xclk_fifo_pkg::word_t data_out,
  output logic [PW-1:0]        rgray
);
  import xclk_fifo_pkg::*;

  logic          wake_q;
  logic [PW-1:0] fetch_q, ret_q, fetch_n, ret_n;
  logic [PW-1:0] wgray_s, wbin, cnt_n;
  logic          avail, take, load;

  xclk_fifo_sync2 #(.W(PW)) u_wsync (
    .clk(clk), .rst_n(rst_n), .d(wgray_async), .q(wgray_s)
  );

  assign wbin    = PW'(gray_to_bin(GMAX'(wgray_s)));
  assign avail   = wake_q && (fetch_q != wbin);
  assign take    = rd_req & ready_out;
  assign load    = avail && (!ready_out || take);
  assign fetch_n = fetch_q + PW'(load);
  assign ret_n   = ret_q + PW'(take);
  assign cnt_n   = wbin - ret_n;
  assign raddr   = fetch_q[AW-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wake_q    <= 1'b0;
      fetch_q   <= '0;
      ret_q     <= '0;
      rgray     <= '0;
      ready_out <= 1'b0;
      ae_n      <= 1'b0;
      data_out  <= '0;
    end else begin
      wake_q  <= 1'b1;
      fetch_q <= fetch_n;
      ret_q   <= ret_n;
      rgray   <= ret_n ^ (ret_n >> 1);
      ae_n    <= cnt_n > xoff;
      if (load) begin
        ready_out <= 1'b1;
        data_out  <= mem_data;
      end else if (take) begin
        ready_out <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/xclk_fifo.sv
module xclk_fifo #(
  parameter int DEPTH = 256,
  localparam int AW = $clog2(DEPTH),
  localparam int PW = AW + 1
) (
  input  logic          rst_n,
  input  logic          wclk,
  input  logic          w_cs_n,
  input  logic          w_en,
  input  logic          w_wr,
  input  logic [35:0]   w_data,
  input  logic [PW-1:0] y_off,
  output logic          w_ir,
  output logic          w_af_n,
  input  logic          rclk,
  input  logic          r_cs_n,
  input  logic          r_en,
  input  logic          r_rd,
  input  logic [PW-1:0] x_off,
  output logic [35:0]   r_data,
  output logic          r_or,
  output logic          r_ae_n
);
  import xclk_fifo_pkg::*;

  logic          we;
  logic [AW-1:0] waddr, raddr;
  logic [PW-1:0] wgray, rgray;
  word_t         mem_q;
  logic          wr_req, rd_req;

  assign wr_req = !w_cs_n && w_en && w_wr;
  assign rd_req = !r_cs_n && r_en && r_rd;

  xclk_fifo_ram #(.DEPTH(DEPTH)) u_ram (
    .wclk(wclk), .we(we), .waddr(waddr), .wdata(w_data),
    .raddr(raddr), .rdata(mem_q)
  );

  xclk_fifo_wside #(.DEPTH(DEPTH)) u_w (
    .clk(wclk), .rst_n(rst_n), .wr_req(wr_req), .rgray_async(rgray),
    .yoff(y_off), .ir(w_ir), .af_n(w_af_n), .we(we), .waddr(waddr),
    .wgray(wgray)
  );

  xclk_fifo_rside #(.DEPTH(DEPTH)) u_r (
    .clk(rclk), .rst_n(rst_n), .rd_req(rd_req), .wgray_async(wgray),
    .xoff(x_off), .mem_data(mem_q), .raddr(raddr), .ready_out(r_or),
    .ae_n(r_ae_n), .data_out(r_data), .rgray(rgray)
  );
endmodule

// File: rtl/xclk_fifo_chk.sv
module xclk_fifo_chk #(
  parameter int PW = 9
) (
  input logic          rst_n,
  input logic          wclk,
  input logic          rclk,
  input logic          w_ir,
  input logic          w_af_n,
  input logic          w_wake,
  input logic [PW-1:0] w_ptr,
  input logic          r_cs_n,
  input logic          r_en,
  input logic          r_rd,
  input logic          r_or,
  input logic          r_ae_n,
  input logic [PW-1:0] r_ret,
  input logic [35:0]   r_data
);
  // R3: a write side that is not ready never moves its pointer
  p_full_blocks_write_r3: assert property (@(posedge wclk) disable iff (!rst_n)
    !w_ir |=> $stable(w_ptr));

  // R5: a read request against an empty FIFO retires nothing
  p_empty_blocks_read_r5: assert property (@(posedge rclk) disable iff (!rst_n)
    !r_or |=> $stable(r_ret));

  // R5: a presented word is held until it is taken
  p_hold_word_r5: assert property (@(posedge rclk) disable iff (!rst_n)
    (r_or && !(!r_cs_n && r_en && r_rd)) |=> (r_or && $stable(r_data)));

  // R7: nothing held means below any almost-empty threshold
  p_empty_is_almost_empty_r7: assert property (@(posedge rclk) disable iff (!rst_n)
    !r_or |-> !r_ae_n);

  // R8: full after wake-up means within any almost-full threshold
  p_full_is_almost_full_r8: assert property (@(posedge wclk) disable iff (!rst_n)
    (!w_ir && $past(w_wake)) |-> !w_af_n);

  // R9: flags held at their reset values while reset is low
  p_reset_flags_r9: assert property (@(posedge wclk)
    !rst_n |-> (!w_ir && w_af_n && !r_or && !r_ae_n));
endmodule

bind xclk_fifo xclk_fifo_chk #(.PW(PW)) u_chk (
  .rst_n(rst_n), .wclk(wclk), .rclk(rclk), .w_ir(w_ir), .w_af_n(w_af_n),
  .w_wake(u_w.wake_q), .w_ptr(u_w.bin_q), .r_cs_n(r_cs_n), .r_en(r_en),
  .r_rd(r_rd), .r_or(r_or), .r_ae_n(r_ae_n), .r_ret(u_r.ret_q),
  .r_data(r_data)
);

// File: tb/tb_xclk_fifo.sv
module tb_xclk_fifo;
  localparam int DEPTH = 256;
  localparam int PW = $clog2(DEPTH) + 1;
  localparam int NSTREAM = 500;

  logic rst_n = 1'b1;
  logic wclk = 1'b0, rclk = 1'b0;
  logic w_cs_n = 1'b1, w_en = 1'b0, w_wr = 1'b0;
  logic [35:0] w_data = '0;
  logic [PW-1:0] y_off = PW'(4), x_off = PW'(4);
  logic r_cs_n = 1'b1, r_en = 1'b0, r_rd = 1'b0;
  logic w_ir, w_af_n, r_or, r_ae_n;
  logic [35:0] r_data;

  int nchk = 0, nerr = 0;

  xclk_fifo #(.DEPTH(DEPTH)) dut (
    .rst_n(rst_n), .wclk(wclk), .w_cs_n(w_cs_n), .w_en(w_en), .w_wr(w_wr),
    .w_data(w_data), .y_off(y_off), .w_ir(w_ir), .w_af_n(w_af_n),
    .rclk(rclk), .r_cs_n(r_cs_n), .r_en(r_en), .r_rd(r_rd), .x_off(x_off),
    .r_data(r_data), .r_or(r_or), .r_ae_n(r_ae_n)
  );

  always #5 wclk = ~wclk;
  initial begin
    #3;
    forever #5 rclk = ~rclk;
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wtick();
    @(posedge wclk);
    #1;
  endtask

  task automatic rtick();
    @(posedge rclk);
    #1;
  endtask

  task automatic wdrive(input bit cs_n, input bit en, input bit wr,
                        input logic [35:0] d);
    w_cs_n = cs_n; w_en = en; w_wr = wr; w_data = d;
  endtask

  task automatic widle();
    wdrive(1'b1, 1'b0, 1'b0, '0);
  endtask

  task automatic rdrive(input bit cs_n, input bit en, input bit rd);
    r_cs_n = cs_n; r_en = en; r_rd = rd;
  endtask

  task automatic finish_up();
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge wclk);
    nerr++;
    $display("FAIL watchdog actual=%0d expected=%0d", 150000, 0);
    finish_up();
  end

  initial begin
    #1 rst_n = 1'b0;
    repeat (6) wtick();
    // R9 reset values
    chk(w_ir == 1'b0, "R9 w_ir in reset", w_ir, 0);
    chk(w_af_n == 1'b1, "R9 w_af_n in reset", w_af_n, 1);
    chk(r_or == 1'b0, "R9 r_or in reset", r_or, 0);
    chk(r_ae_n == 1'b0, "R9 r_ae_n in reset", r_ae_n, 0);
    #2 rst_n = 1'b1;
    wtick();
    chk(w_ir == 1'b0, "R4 first edge after reset", w_ir, 0);
    wtick();
    chk(w_ir == 1'b1, "R4 second edge after reset", w_ir, 1);
    repeat (3) rtick();

    // R6 latency from write into empty to r_or
    wdrive(1'b0, 1'b1, 1'b1, 36'hA5A5A5A5A);
    wtick();
    widle();
    for (int k = 1; k <= 3; k++) begin
      rtick();
      chk(r_or == (k == 3), "R6 r_or after write into empty", r_or, (k == 3));
    end
    chk(r_data == 36'hA5A5A5A5A, "R5 fall-through data", r_data, 36'hA5A5A5A5A);
    chk(r_ae_n == 1'b0, "R7 one word under threshold 4", r_ae_n, 0);
    rdrive(1'b0, 1'b1, 1'b1);
    rtick();
    rdrive(1'b1, 1'b0, 1'b0);
    chk(r_or == 1'b0, "R10 last word taken", r_or, 0);

    // R5: reads while empty do nothing
    rdrive(1'b0, 1'b1, 1'b1);
    repeat (3) rtick();
    rdrive(1'b1, 1'b0, 1'b0);
    chk(r_or == 1'b0, "R5 empty read", r_or, 0);

    // R1: each disqualified write leaves nothing behind
    wdrive(1'b1, 1'b1, 1'b1, 36'h0BAD00001); wtick();
    wdrive(1'b0, 1'b0, 1'b1, 36'h0BAD00002); wtick();
    wdrive(1'b0, 1'b1, 1'b0, 36'h0BAD00003); wtick();
    wdrive(1'b0, 1'b1, 1'b1, 36'h000000111); wtick();
    widle();
    repeat (5) rtick();
    chk(r_or == 1'b1, "R1 qualified write seen", r_or, 1);
    chk(r_data == 36'h111, "R1 disqualified writes dropped", r_data, 36'h111);
    // R1: each disqualified read leaves the word in place
    rdrive(1'b1, 1'b1, 1'b1); rtick();
    rdrive(1'b0, 1'b0, 1'b1); rtick();
    rdrive(1'b0, 1'b1, 1'b0); rtick();
    rdrive(1'b1, 1'b0, 1'b0);
    chk(r_or == 1'b1 && r_data == 36'h111, "R1 disqualified reads ignored",
        r_data, 36'h111);
    rdrive(1'b0, 1'b1, 1'b1); rtick();
    rdrive(1'b1, 1'b0, 1'b0);
    chk(r_or == 1'b0, "R1 qualified read taken", r_or, 0);
    repeat (4) wtick();

    // Fill and drain sweeps over threshold pairs
    for (int p = 0; p < 3; p++) begin
      int xv, yv;
      logic [35:0] base;
      xv = (p == 0) ? 4 : (p == 1) ? 0 : 100;
      yv = (p == 0) ? 4 : (p == 1) ? 7 : 250;
      base = 36'h100000000 * (p + 1);
      x_off = PW'(xv);
      y_off = PW'(yv);
      wtick();
      for (int n = 1; n <= DEPTH; n++) begin
        wdrive(1'b0, 1'b1, 1'b1, base + 36'(n - 1));
        wtick();
        chk(w_af_n == ((DEPTH - n) > yv), "R8 almost-full while filling",
            w_af_n, ((DEPTH - n) > yv));
        chk(w_ir == (n < DEPTH), "R3 input ready at capacity", w_ir, (n < DEPTH));
      end
      wdrive(1'b0, 1'b1, 1'b1, 36'hDEADDEAD0);
      repeat (2) wtick();
      widle();
      chk(w_ir == 1'b0, "R3 still full after refused writes", w_ir, 0);
      repeat (6) rtick();
      chk(r_or == 1'b1, "R5 ready when full", r_or, 1);
      chk(r_ae_n == (DEPTH > xv), "R7 almost-empty when full", r_ae_n, (DEPTH > xv));
      rdrive(1'b0, 1'b1, 1'b1);
      for (int n = 1; n <= DEPTH; n++) begin
        chk(r_data == base + 36'(n - 1), "R2 order on drain", r_data,
            base + 36'(n - 1));
        rtick();
        chk(r_ae_n == ((DEPTH - n) > xv), "R7 almost-empty while draining",
            r_ae_n, ((DEPTH - n) > xv));
        chk(r_or == (n < DEPTH), "R10 ready while draining", r_or, (n < DEPTH));
      end
      rdrive(1'b1, 1'b0, 1'b0);
      repeat (6) wtick();
      chk(w_ir == 1'b1, "R3 ready again after drain", w_ir, 1);
      chk(w_af_n == 1'b1, "R8 clear after drain", w_af_n, 1);
    end

    // R2: concurrent streaming with patterned back-pressure
    x_off = PW'(4);
    y_off = PW'(4);
    fork
      begin
        int sent = 0;
        int cyc = 0;
        while (sent < NSTREAM) begin
          bit go;
          go = (cyc % 3) != 2;
          if (go) wdrive(1'b0, 1'b1, 1'b1, 36'h500000000 + 36'(sent));
          else widle();
          if (go && w_ir) sent++;
          wtick();
          cyc++;
        end
        widle();
      end
      begin
        int got = 0;
        int cyc = 0;
        while (got < NSTREAM) begin
          if (r_or && (cyc % 4) != 1) begin
            chk(r_data == 36'h500000000 + 36'(got), "R2 streaming order", r_data,
                36'h500000000 + 36'(got));
            rdrive(1'b0, 1'b1, 1'b1);
            got++;
          end else begin
            rdrive(1'b1, 1'b0, 1'b0);
          end
          rtick();
          cyc++;
        end
        rdrive(1'b1, 1'b0, 1'b0);
      end
    join
    repeat (6) rtick();
    chk(r_or == 1'b0, "R2 nothing extra after stream", r_or, 0);
    finish_up();
  end
endmodule